// File: doc/BRIEF.md
# Overlapping-Carrier Multilevel PWM Modulator

This block produces the switching level commands for a three-phase, seven-level cascaded bridge inverter. It compares a sampled sine reference for each phase against six triangular carriers. All carriers run at one frequency with one peak-to-peak height. Each carrier sits half a carrier height above the one below it, so neighbouring carrier bands overlap rather than tile the range. For each phase, the output level is the number of carriers that the reference lies above, shifted so that the result is a signed value from -3 to +3. The raw comparator bits are also brought out.

The reference samples come from a quarter-wave sine table that is computed at elaboration. The three phases read this table at index offsets of one third of a period. Each sample is scaled by a modulation index in Q1.15 and loaded once per carrier period, at the carrier trough. The carrier height is the parameter `CAR_AC`, measured in counts per half period. The parameter `MF_RATIO` gives the number of carrier periods per reference period. When the enable input is low, the block stays idle with all outputs at zero, and the carrier and the phase restart from zero.

Top module: `ocpwm_modulator`

## Requirements
- R1: The carrier count t runs 0,1,…,CAR_AC,CAR_AC-1,…,1 and then repeats, so one carrier period is 2·CAR_AC cycles. Carrier k (k = 0..5) has the value t + k·CAR_AC/2 − 7·CAR_AC/4, which makes neighbouring carriers overlap by half their height.
- R2: Bit 6p+k of `cmp_bits` is 1 exactly when the held reference of phase p (p = 0,1,2) is strictly greater than carrier k. The bit is registered one cycle after the carrier value and the reference it compares.
- R3: Inside each phase, the six comparator bits always form a thermometer code: if bit k+1 is set, then bit k is also set.
- R4: Bits [3p+2:3p] of `level_out` hold a two's-complement level for phase p. This level equals the number of set comparator bits of that phase minus 3, which gives a range of -3..+3.
- R5: A phase reference changes only at the edge where the carrier count is 0. At that edge the table index advances by TBL_PER/MF_RATIO, so one reference period spans MF_RATIO carrier periods.
- R6: A loaded reference equals ma·sin(2π·i/TBL_PER)·7·CAR_AC/4, truncated to an integer, where ma = `ma_q15`/32768 and i is the phase's table index. The reference is therefore centred on zero, and an index of 1.0 spans the whole carrier band.
- R7: Phase 1 reads the table at index +2·TBL_PER/3 and phase 2 at +TBL_PER/3. As a result, the phase-1 and phase-2 level sequences equal the phase-0 sequence delayed by one third and two thirds of a reference period.
- R8: With `ma_q15` = 32768, every phase reaches each of the levels -3..+3 within one reference period.
- R9: While `enable` is low, `level_out` and `cmp_bits` are 0 after the next edge. The carrier count, the table index and the references reset, so that enabling starts again from the beginning.
- R10: A synchronous reset clears `level_out`, `cmp_bits`, the carrier, the table index and the references on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the modulator; when low, the block idles with zero outputs |
| ma_q15 | input | 16 | Modulation index, unsigned Q1.15 (32768 = 1.0) |
| level_out | output | 9 | Three signed 3-bit level commands, phase p at [3p+2:3p] |
| cmp_bits | output | 18 | Comparator bits, phase p carrier k at bit 6p+k |

## Verification
On every cycle, the assertions check the following: the carrier moves by one count per enabled cycle and stays inside its range; the comparator bits of each phase form a thermometer; each level matches its bit count; a reference changes only at a trough; and reset and idle clear the outputs. Some behaviour depends on the sine values and on whole reference periods, and only the bench scenarios can show it. The bench compares the comparator bits with a floating-point sine model, skipping bits whose margin is two counts or less. It confirms that all seven levels are reached at full index, and that the three phase sequences are exact shifts of one third of a period.

// File: rtl/ocpwm_pkg.sv
package ocpwm_pkg;

    localparam int NUM_LEVELS = 7;
    localparam int NUM_CAR    = NUM_LEVELS - 1;
    localparam int NUM_PH     = 3;
    localparam int LVL_MID    = (NUM_LEVELS - 1) / 2;
    localparam int LVL_W      = $clog2(NUM_LEVELS);
    localparam int SIN_W      = 16;
    localparam int SIN_MAX    = 32767;
    localparam int MA_W       = 16;
    localparam int PROD_SHIFT = 30;

    typedef enum logic {
        SLOPE_UP   = 1'b0,
        SLOPE_DOWN = 1'b1
    } slope_e;

    typedef struct packed {
        logic [NUM_CAR-1:0]      above;
        logic signed [LVL_W-1:0] level;
    } slice_t;

    // Rational sine approximation over the first quarter wave:
    // sin(x) ~ 16u / (5H^2 - 4u), u = i*(H-i), H = half period in table steps.
    function automatic logic [SIN_W-1:0] quarter_sine(int i, int qtr);
        longint h;
        longint u;
        longint num;
        longint den;
        h   = 2 * longint'(qtr);
        u   = longint'(i) * (h - longint'(i));
        num = longint'(SIN_MAX) * 16 * u;
        den = 5 * h * h - 4 * u;
        return SIN_W'((num + den / 2) / den);
    endfunction

    // Vertical offset of carrier k: half a carrier height per step, band centred on 0.
    function automatic int carrier_offset(int k, int ac);
        return k * ac / 2 - (NUM_CAR + 1) * ac / 4;
    endfunction

    function automatic logic signed [LVL_W-1:0] count_to_level(logic [NUM_CAR-1:0] a);
        return LVL_W'($countones(a) - LVL_MID);
    endfunction

endpackage

// File: rtl/ocpwm_carrier.sv
module ocpwm_carrier
    import ocpwm_pkg::*;
#(
    parameter int CAR_AC = 64,
    parameter int CNT_W  = $clog2(CAR_AC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] tri_cnt,
    output logic             trough
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(CAR_AC);

    slope_e slope;

    assign trough = en && (tri_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tri_cnt <= '0;
            slope   <= SLOPE_UP;
        end else if (tri_cnt == '0) begin
            tri_cnt <= CNT_W'(1);
            slope   <= SLOPE_UP;
        end else if (slope == SLOPE_UP) begin
            if (tri_cnt == TOP) begin
                tri_cnt <= TOP - 1'b1;
                slope   <= SLOPE_DOWN;
            end else begin
                tri_cnt <= tri_cnt + 1'b1;
            end
        end else begin
            tri_cnt <= tri_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/ocpwm_ref_gen.sv
module ocpwm_ref_gen
    import ocpwm_pkg::*;
#(
    parameter int CAR_AC   = 64,
    parameter int MF_RATIO = 24,
    parameter int TBL_PER  = 96,
    parameter int CW       = 10
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic                         trough,
    input  logic [MA_W-1:0]              ma_q15,
    output logic [NUM_PH-1:0][CW-1:0]    ref_bus
);

    // TBL_PER must be a multiple of 12 and of MF_RATIO.
    localparam int QTR      = TBL_PER / 4;
    localparam int STEP     = TBL_PER / MF_RATIO;
    localparam int IDX_W    = $clog2(TBL_PER);
    localparam int QW       = $clog2(QTR + 1);
    localparam int REF_PEAK = (NUM_CAR + 1) * CAR_AC / 4;

    logic [SIN_W-1:0] qtab [QTR+1];
    logic [IDX_W-1:0] phase_idx;

    for (genvar i = 0; i <= QTR; i++) begin : g_tab
        assign qtab[i] = quarter_sine(i, QTR);
    end

    function automatic logic [IDX_W-1:0] wrap_add(logic [IDX_W-1:0] a, int b);
        int s;
        s = int'(a) + b;
        if (s >= TBL_PER) s = s - TBL_PER;
        return IDX_W'(s);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase_idx <= '0;
        end else if (trough) begin
            phase_idx <= wrap_add(phase_idx, STEP);
        end
    end

    for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
        localparam int OFF = (p == 0) ? 0 : ((p == 1) ? 2 * TBL_PER / 3 : TBL_PER / 3);

        logic [IDX_W-1:0]        tap;
        logic [QW-1:0]           row;
        logic                    neg;
        logic signed [SIN_W:0]   sin_s;
        logic signed [CW-1:0]    scaled;
        logic signed [CW-1:0]    ref_q;

        always_comb begin
            int t;
            int q;
            int r;
            longint prod;
            tap  = wrap_add(phase_idx, OFF);
            t    = int'(tap);
            q    = t / QTR;
            r    = t - q * QTR;
            row  = ((q % 2) == 1) ? QW'(QTR - r) : QW'(r);
            neg  = (q >= 2);
            sin_s = neg ? -$signed({1'b0, qtab[row]}) : $signed({1'b0, qtab[row]});
            prod = longint'(sin_s) * longint'({1'b0, ma_q15}) * longint'(REF_PEAK);
            scaled = CW'(prod >>> PROD_SHIFT);
        end

        always_ff @(posedge clk) begin
            if (rst || !en) begin
                ref_q <= '0;
            end else if (trough) begin
                ref_q <= scaled;
            end
        end

        assign ref_bus[p] = ref_q;
    end

endmodule

// File: rtl/ocpwm_slicer.sv
module ocpwm_slicer
    import ocpwm_pkg::*;
#(
    parameter int CAR_AC = 64,
    parameter int CNT_W  = 7,
    parameter int CW     = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [CNT_W-1:0]     tri_cnt,
    input  logic signed [CW-1:0] ref_in,
    output slice_t               slice
);

    logic [NUM_CAR-1:0] above_d;

    for (genvar k = 0; k < NUM_CAR; k++) begin : g_car
        localparam int OFS = carrier_offset(k, CAR_AC);
        logic signed [CW-1:0] car;
        assign car        = CW'(int'(tri_cnt) + OFS);
        assign above_d[k] = (ref_in > car);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            slice <= '0;
        end else begin
            slice.above <= above_d;
            slice.level <= count_to_level(above_d);
        end
    end

endmodule

// File: rtl/ocpwm_modulator.sv
module ocpwm_modulator
    import ocpwm_pkg::*;
#(
    parameter int CAR_AC   = 64,
    parameter int MF_RATIO = 24,
    parameter int TBL_PER  = 96
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        enable,
    input  logic [MA_W-1:0]             ma_q15,
    output logic [NUM_PH*LVL_W-1:0]     level_out,
    output logic [NUM_PH*NUM_CAR-1:0]   cmp_bits
);

    localparam int CNT_W = $clog2(CAR_AC + 1);
    localparam int CW    = $clog2(4 * CAR_AC) + 2;

    logic [CNT_W-1:0]              tri_cnt;
    logic                          trough;
    logic [NUM_PH-1:0][CW-1:0]     ref_bus;
    slice_t                        slices [NUM_PH];

    ocpwm_carrier #(
        .CAR_AC (CAR_AC),
        .CNT_W  (CNT_W)
    ) i_carrier (
        .clk     (clk),
        .rst     (rst),
        .en      (enable),
        .tri_cnt (tri_cnt),
        .trough  (trough)
    );

    ocpwm_ref_gen #(
        .CAR_AC   (CAR_AC),
        .MF_RATIO (MF_RATIO),
        .TBL_PER  (TBL_PER),
        .CW       (CW)
    ) i_ref_gen (
        .clk     (clk),
        .rst     (rst),
        .en      (enable),
        .trough  (trough),
        .ma_q15  (ma_q15),
        .ref_bus (ref_bus)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_slice
        ocpwm_slicer #(
            .CAR_AC (CAR_AC),
            .CNT_W  (CNT_W),
            .CW     (CW)
        ) i_slicer (
            .clk     (clk),
            .rst     (rst),
            .en      (enable),
            .tri_cnt (tri_cnt),
            .ref_in  ($signed(ref_bus[p])),
            .slice   (slices[p])
        );

        assign level_out[p*LVL_W +: LVL_W]    = slices[p].level;
        assign cmp_bits[p*NUM_CAR +: NUM_CAR] = slices[p].above;
    end

endmodule

// File: rtl/ocpwm_checker.sv
module ocpwm_checker
    import ocpwm_pkg::*;
#(
    parameter int CAR_AC = 64,
    parameter int CNT_W  = 7,
    parameter int CW     = 10
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        enable,
    input logic [NUM_PH*LVL_W-1:0]     level_out,
    input logic [NUM_PH*NUM_CAR-1:0]   cmp_bits,
    input logic [CNT_W-1:0]            tri_cnt,
    input logic                        trough,
    input logic [NUM_PH-1:0][CW-1:0]   ref_bus
);

    logic rst_d = 1'b0;

    // R10: outputs are clear in the cycle after a reset edge
    always @(posedge clk) begin
        if (rst_d) begin
            p_reset_clear_r10: assert (level_out == '0 && cmp_bits == '0);
        end
        rst_d <= rst;
    end

    // R1: carrier stays inside its band and moves one count per enabled cycle
    p_carrier_range_r1: assert property (@(posedge clk) disable iff (rst)
        int'(tri_cnt) <= CAR_AC);

    p_carrier_step_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(enable) && !$past(rst)) |->
            ((int'(tri_cnt) == int'($past(tri_cnt)) + 1) ||
             (int'(tri_cnt) + 1 == int'($past(tri_cnt)))));

    // R5: a reference moves only on a trough edge
    p_ref_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(enable) && !$past(rst) && !$past(trough)) |-> $stable(ref_bus));

    // R9: idle input clears outputs
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (level_out == '0 && cmp_bits == '0));

    for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
        logic [NUM_CAR-1:0]      bits_p;
        logic signed [LVL_W-1:0] lvl_p;
        assign bits_p = cmp_bits[p*NUM_CAR +: NUM_CAR];
        assign lvl_p  = level_out[p*LVL_W +: LVL_W];

        // R3: thermometer code inside a phase
        p_thermo_r3: assert property (@(posedge clk) disable iff (rst)
            ((bits_p >> 1) & ~bits_p) == '0);

        // R4: level equals set-bit count minus the mid level
        p_level_sum_r4: assert property (@(posedge clk) disable iff (rst)
            ($past(enable) && !$past(rst)) |->
                (int'(lvl_p) == $countones(bits_p) - LVL_MID));
    end

endmodule

bind ocpwm_modulator ocpwm_checker #(
    .CAR_AC (CAR_AC),
    .CNT_W  (CNT_W),
    .CW     (CW)
) i_ocpwm_checker (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .level_out (level_out),
    .cmp_bits  (cmp_bits),
    .tri_cnt   (tri_cnt),
    .trough    (trough),
    .ref_bus   (ref_bus)
);

// File: tb/test_ocpwm_modulator.sv
module test_ocpwm_modulator;

    localparam int AC     = 16;
    localparam int MF     = 24;
    localparam int PER    = 96;
    localparam int STEP   = PER / MF;
    localparam int REFPER = MF * 2 * AC;
    localparam int SHIFT  = (MF / 3) * 2 * AC;
    localparam int NREC   = 3 * REFPER;
    localparam real PEAK  = 7.0 * AC / 4.0;
    localparam real PI    = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [15:0] ma_q15 = 16'd0;
    logic [8:0]  level_out;
    logic [17:0] cmp_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int  m_cnt = 0;
    bit  m_up = 1'b1;
    int  m_idx = 0;
    real m_ref [3];
    int  offs [3] = '{0, 2 * PER / 3, PER / 3};

    bit  rec_on = 1'b0;
    int  rec_n = 0;
    int  rec_lvl [3][NREC];

    always #5 clk = ~clk;

    ocpwm_modulator #(
        .CAR_AC   (AC),
        .MF_RATIO (MF),
        .TBL_PER  (PER)
    ) i_ocpwm_modulator (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .ma_q15    (ma_q15),
        .level_out (level_out),
        .cmp_bits  (cmp_bits)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic real model_ref(int ma, int idx);
        return (real'(ma) / 32768.0) * $sin(2.0 * PI * real'(idx % PER) / real'(PER)) * PEAK;
    endfunction

    function automatic int lvl_of(int p);
        return int'($signed(level_out[3*p +: 3]));
    endfunction

    task automatic step();
        bit          idle;
        logic [5:0]  exp_b [3];
        logic [5:0]  mask [3];
        idle = rst || !enable;
        if (idle) begin
            m_cnt = 0; m_up = 1'b1; m_idx = 0;
            for (int p = 0; p < 3; p++) m_ref[p] = 0.0;
        end else begin
            for (int p = 0; p < 3; p++) begin
                for (int k = 0; k < 6; k++) begin
                    real d;
                    d = m_ref[p] - real'(m_cnt + k * AC / 2 - 7 * AC / 4);
                    exp_b[p][k] = (d > 0.0);
                    mask[p][k]  = (d > 2.0) || (d < -2.0);
                end
            end
            if (m_cnt == 0) begin
                for (int p = 0; p < 3; p++) m_ref[p] = model_ref(int'(ma_q15), m_idx + offs[p]);
                m_idx = (m_idx + STEP) % PER;
            end
            if (m_cnt == 0) begin m_cnt = 1; m_up = 1'b1; end
            else if (m_up) begin
                if (m_cnt == AC) begin m_cnt = AC - 1; m_up = 1'b0; end
                else m_cnt++;
            end else m_cnt--;
        end
        @(posedge clk);
        @(negedge clk);
        if (idle) begin
            chk(level_out == '0 && cmp_bits == '0, rst ? "R10 reset clears outputs" : "R9 idle outputs zero",
                int'({level_out, cmp_bits}), 0);
        end else begin
            for (int p = 0; p < 3; p++) begin
                logic [5:0] b;
                b = cmp_bits[6*p +: 6];
                chk(((b ^ exp_b[p]) & mask[p]) == '0, "R1 R2 R6 comparator bits vs sine model",
                    int'(b), int'(exp_b[p]));
                chk(((b >> 1) & ~b) == '0, "R3 thermometer bits", int'(b), 0);
                chk(lvl_of(p) == $countones(b) - 3, "R4 level from bit count",
                    lvl_of(p), $countones(b) - 3);
                if (rec_on && rec_n < NREC) rec_lvl[p][rec_n] = lvl_of(p);
            end
            if (rec_on && rec_n < NREC) rec_n++;
        end
    endtask

    initial begin
        void'($urandom(32'd7391));
        // reset
        rst = 1'b1; enable = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        repeat (3) step();
        // full index: record three reference periods
        ma_q15 = 16'd32768; enable = 1'b1; rec_on = 1'b1;
        repeat (NREC) step();
        rec_on = 1'b0;
        for (int p = 0; p < 3; p++) begin
            bit seen [7];
            int miss;
            miss = 0;
            for (int v = 0; v < 7; v++) seen[v] = 1'b0;
            for (int n = 2 * REFPER; n < NREC; n++) seen[rec_lvl[p][n] + 3] = 1'b1;
            for (int v = 0; v < 7; v++) if (!seen[v]) miss++;
            chk(miss == 0, "R8 all levels reached in one period", 7 - miss, 7);
        end
        begin
            int bad1;
            int bad2;
            bad1 = 0; bad2 = 0;
            for (int n = 2 * REFPER; n < NREC; n++) begin
                if (rec_lvl[1][n] != rec_lvl[0][n - SHIFT]) bad1++;
                if (rec_lvl[2][n] != rec_lvl[0][n - 2 * SHIFT]) bad2++;
            end
            chk(bad1 == 0, "R7 phase 1 lags phase 0 by a third", bad1, 0);
            chk(bad2 == 0, "R7 phase 2 lags phase 0 by two thirds", bad2, 0);
        end
        // R9: drop enable mid-run, then restart from the beginning
        enable = 1'b0;
        repeat (5) step();
        enable = 1'b1;
        repeat (200) step();
        // R6 directed corners: zero index and maximum index
        ma_q15 = 16'd0;
        repeat (REFPER) step();
        ma_q15 = 16'hFFFF;
        repeat (REFPER) step();
        // random index segments with occasional enable drops
        for (int s = 0; s < 6; s++) begin
            ma_q15 = 16'($urandom_range(0, 65535));
            for (int n = 0; n < 400; n++) begin
                enable = ($urandom_range(0, 99) != 0);
                step();
            end
        end
        // R10: reset in mid-run
        enable = 1'b1;
        repeat (50) step();
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        repeat (100) step();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule